// File: doc/BRIEF.md
# Main Clock Source Switch Controller

This block selects where the system clock comes from. After reset the system clock runs from the internal high-speed oscillator. Software can then start an external crystal or resonator oscillator, wait until it has run long enough to be stable, and move the system clock onto it without glitches. All of this is done through five byte-wide registers. The register interface and all control state live in the internal clock domain.

Once software clears the main-stop bit, a settling counter in the external clock domain counts oscillator cycles. It raises eight cumulative progress flags at uneven power-of-two milestones. A 3-bit settle code picks one of those milestones as the earliest point at which the system clock may switch. The switch itself is a cross-coupled enable pair. Each side is synchronized in its own domain and gated on its own falling edge. A read-only status bit reports the source that is actually in use. The analog oscillator and the clock-mux cell are modelled as an enable output and a clock input.

The parameter `BASE_EXP` sets the lowest milestone at 2^BASE_EXP cycles (default 8). The eight milestones are 2^(BASE_EXP + k) for k in {0, 1, 2, 3, 5, 7, 9, 10}.

Top module: `mclk_switch_ctrl`

## Requirements
- R1: After reset the registers read as follows. Address 0 (mode) reads 0x00. Address 1 (stop) reads 0x01. Address 2 (settle code) reads 0x07. Address 3 (progress flags) reads 0x00. Address 4 (clock control) reads 0x00. `osc_run` is 0, and `sys_clk_out` follows `int_clk`.
- R2: In the mode register (address 0), bit 0 drives `osc_xtal` (crystal mode) and bit 1 drives `osc_hgain` (high-gain drive, needed at 10 MHz and above). Both fields are writable at any time.
- R3: Bit 0 of address 1 is the main-stop bit. `osc_run` equals its inverse. Writing 0 starts the oscillator and the settling counter.
- R4: Bit i of address 3 sets once the counter has seen 2^(BASE_EXP + k_i) external cycles, with k = {0,1,2,3,5,7,9,10} for i = 0..7. The flags therefore always form a thermometer code that fills from bit 0 upward.
- R5: Writing main-stop = 1 while the internal source is active and bit 0 of address 4 is 0 takes effect. `osc_run` drops, and address 3 reads 0x00 within three internal cycles.
- R6: Settle code n (address 2, bits 2:0) selects flag n. The select bit (address 4, bit 0) takes effect only once flag n is set. Until then the status bit (address 4, bit 1) reads 0. It reads 1 within 16 internal cycles after flag n is seen.
- R7: The internal and external clock enables are never on together. `sys_clk_out` carries the source that the status bit reports.
- R8: A write of main-stop = 1 is ignored while the select bit is 1 or the external source is still active. The stop bit stays 0 and `osc_run` stays 1.
- R9: Reserved bits and unmapped addresses 5 to 7 read 0 and ignore writes. Writes to address 3 are ignored.
- R10: Clearing the select bit returns the system clock to the internal source. The status bit reads 0 within 16 internal cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Internal high-speed oscillator clock; register domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External oscillator clock (toggles only while running) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| osc_run | output | 1 | External oscillator enable |
| osc_xtal | output | 1 | Crystal/resonator mode select for the pin pair |
| osc_hgain | output | 1 | High-gain oscillator drive |
| sys_clk_out | output | 1 | Glitch-free system clock |

## Verification
The assertions assume that software keeps the settle code and the select bit steady while a switch to the external source is in flight. They also assume the external clock keeps running whenever `osc_run` is high. The bench follows both rules. It writes the settle code before it sets the select bit, changes neither until the status bit has settled, and toggles its modelled oscillator only while `osc_run` is asserted. Random register traffic is confined to the mode, settle, status and unmapped addresses while the oscillator is stopped, so it cannot start a switch.

// File: rtl/mclk_sw_pkg.sv
package mclk_sw_pkg;

    localparam int NUM_MS = 8;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CODE_W = $clog2(NUM_MS);

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_STOP   = 3'd1,
        A_SETTLE = 3'd2,
        A_FLAGS  = 3'd3,
        A_CLKCTL = 3'd4
    } reg_addr_e;

    // exponent offset of each progress milestone above the base exponent
    function automatic int ms_step(input int idx);
        case (idx)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 5;
            5: return 7;
            6: return 9;
            default: return 10;
        endcase
    endfunction

    typedef struct packed {
        logic              xtal;
        logic              hgain;
        logic              mstop;
        logic [CODE_W-1:0] code;
        logic              sel;
        logic              req;
        logic [NUM_MS-1:0] flag_s1;
        logic [NUM_MS-1:0] flag_s2;
        logic              stat_s1;
        logic              stat_s2;
    } ctl_regs_t;

endpackage

// File: rtl/mclk_settle_cnt.sv
module mclk_settle_cnt
    import mclk_sw_pkg::*;
#(
    parameter int BASE_EXP = 8
) (
    input  logic              ext_clk,
    input  logic              ext_rst_n,
    output logic [NUM_MS-1:0] flags
);

    localparam int TOP_EXP = BASE_EXP + ms_step(NUM_MS - 1);
    localparam int CNT_W   = TOP_EXP + 1;
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(1) << TOP_EXP;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [NUM_MS-1:0] flags;
    } cnt_regs_t;

    cnt_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CNT_LIMIT) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        for (int i = 0; i < NUM_MS; i++) begin
            st_d.flags[i] = (st_q.cnt >= (CNT_W'(1) << (BASE_EXP + ms_step(i))));
        end
    end

    always_ff @(posedge ext_clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/mclk_rst_sync.sv
module mclk_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/mclk_gf_mux.sv
module mclk_gf_mux (
    input  logic int_clk,
    input  logic int_rst_n,
    input  logic ext_clk,
    input  logic ext_rst_n,
    input  logic want_ext,
    output logic int_en,
    output logic ext_en,
    output logic clk_out
);

    logic [1:0] i_sync_q;
    logic [1:0] e_sync_q;
    logic       i_en_q;
    logic       e_en_q;

    // internal side: synchronize the hand-back condition, gate on falling edge
    always_ff @(posedge int_clk or negedge int_rst_n) begin
        if (!int_rst_n) begin
            i_sync_q <= 2'b11;
        end else begin
            i_sync_q <= {i_sync_q[0], ~want_ext & ~e_en_q};
        end
    end

    always_ff @(negedge int_clk or negedge int_rst_n) begin
        if (!int_rst_n) begin
            i_en_q <= 1'b1;
        end else begin
            i_en_q <= i_sync_q[1];
        end
    end

    // external side: same structure in the oscillator domain
    always_ff @(posedge ext_clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            e_sync_q <= 2'b00;
        end else begin
            e_sync_q <= {e_sync_q[0], want_ext & ~i_en_q};
        end
    end

    always_ff @(negedge ext_clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            e_en_q <= 1'b0;
        end else begin
            e_en_q <= e_sync_q[1];
        end
    end

    assign int_en  = i_en_q;
    assign ext_en  = e_en_q;
    assign clk_out = (int_clk & i_en_q) | (ext_clk & e_en_q);

endmodule

// File: rtl/mclk_switch_ctrl.sv
module mclk_switch_ctrl
    import mclk_sw_pkg::*;
#(
    parameter int BASE_EXP = 8
) (
    input  logic              int_clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              osc_run,
    output logic              osc_xtal,
    output logic              osc_hgain,
    output logic              sys_clk_out
);

    ctl_regs_t st_d, st_q;

    logic              ext_arst_n;
    logic              ext_rst_n;
    logic [NUM_MS-1:0] ext_flags;
    logic [NUM_MS-1:0] flags_sync;
    logic              int_en;
    logic              ext_en;
    logic              stat_ext;
    logic              sel_bit;
    logic [CODE_W-1:0] code;

    // the external domain is held cleared while main-stop is set
    assign ext_arst_n = rst_n & ~st_q.mstop;

    mclk_rst_sync #(.STAGES(2)) u_ext_rst (
        .clk    (ext_clk),
        .arst_n (ext_arst_n),
        .srst_n (ext_rst_n)
    );

    mclk_settle_cnt #(.BASE_EXP(BASE_EXP)) u_cnt (
        .ext_clk   (ext_clk),
        .ext_rst_n (ext_rst_n),
        .flags     (ext_flags)
    );

    mclk_gf_mux u_mux (
        .int_clk   (int_clk),
        .int_rst_n (rst_n),
        .ext_clk   (ext_clk),
        .ext_rst_n (ext_rst_n),
        .want_ext  (st_q.req),
        .int_en    (int_en),
        .ext_en    (ext_en),
        .clk_out   (sys_clk_out)
    );

    always_comb begin
        st_d         = st_q;
        st_d.flag_s1 = ext_flags;
        st_d.flag_s2 = st_q.flag_s1;
        st_d.stat_s1 = ext_en;
        st_d.stat_s2 = st_q.stat_s1;
        // once granted, the request holds until the select bit is cleared
        st_d.req     = st_q.sel & (st_q.req | st_q.flag_s2[st_q.code]);
        if (wr_en) begin
            case (addr)
                A_MODE: begin
                    st_d.xtal  = wr_data[0];
                    st_d.hgain = wr_data[1];
                end
                A_STOP: begin
                    if (!wr_data[0]) begin
                        st_d.mstop = 1'b0;
                    end else if (!st_q.sel && !st_q.req && !st_q.stat_s2 && int_en) begin
                        st_d.mstop = 1'b1;
                    end
                end
                A_SETTLE: st_d.code = wr_data[CODE_W-1:0];
                A_CLKCTL: st_d.sel  = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mstop <= 1'b1;
            st_q.code  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            A_MODE:   rd_data = {{(DATA_W-2){1'b0}}, st_q.hgain, st_q.xtal};
            A_STOP:   rd_data = {{(DATA_W-1){1'b0}}, st_q.mstop};
            A_SETTLE: rd_data = {{(DATA_W-CODE_W){1'b0}}, st_q.code};
            A_FLAGS:  rd_data = st_q.flag_s2;
            A_CLKCTL: rd_data = {{(DATA_W-2){1'b0}}, st_q.stat_s2, st_q.sel};
            default:  rd_data = '0;
        endcase
    end

    assign osc_run    = ~st_q.mstop;
    assign osc_xtal   = st_q.xtal;
    assign osc_hgain  = st_q.hgain;
    assign flags_sync = st_q.flag_s2;
    assign stat_ext   = st_q.stat_s2;
    assign sel_bit    = st_q.sel;
    assign code       = st_q.code;

endmodule

// File: rtl/mclk_sw_chk.sv
module mclk_sw_chk
    import mclk_sw_pkg::*;
(
    input logic              int_clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              osc_run,
    input logic [NUM_MS-1:0] flags_sync,
    input logic [NUM_MS-1:0] ext_flags,
    input logic              int_en,
    input logic              ext_en,
    input logic              stat_ext,
    input logic              sel_bit,
    input logic [CODE_W-1:0] code
);

    p_thermo_sync_r4: assert property (@(posedge int_clk) disable iff (!rst_n)
        (flags_sync & (flags_sync + NUM_MS'(1))) == '0);

    p_thermo_ext_r4: assert property (@(posedge int_clk) disable iff (!rst_n)
        (ext_flags & (ext_flags + NUM_MS'(1))) == '0);

    p_clear_r5: assert property (@(posedge int_clk) disable iff (!rst_n)
        $rose(!osc_run) |=> (ext_flags == '0));

    p_switch_gated_r6: assert property (@(posedge int_clk) disable iff (!rst_n)
        $rose(stat_ext) |-> (sel_bit && flags_sync[code]));

    p_excl_r7: assert property (@(posedge int_clk) disable iff (!rst_n)
        !(int_en && ext_en));

    p_stop_hold_r8: assert property (@(posedge int_clk) disable iff (!rst_n)
        stat_ext |-> osc_run);

    p_resv_r9: assert property (@(posedge int_clk) disable iff (!rst_n)
        (addr == A_STOP) |-> (rd_data[DATA_W-1:1] == '0));

endmodule

bind mclk_switch_ctrl mclk_sw_chk u_chk (
    .int_clk    (int_clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_data    (rd_data),
    .osc_run    (osc_run),
    .flags_sync (flags_sync),
    .ext_flags  (ext_flags),
    .int_en     (int_en),
    .ext_en     (ext_en),
    .stat_ext   (stat_ext),
    .sel_bit    (sel_bit),
    .code       (code)
);

// File: tb/mclk_switch_ctrl_tb_top.sv
module mclk_switch_ctrl_tb_top;

    localparam int BASE = 2;

    logic       int_clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [2:0] addr    = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       osc_run, osc_xtal, osc_hgain, sys_clk_out;

    int n_chk = 0;
    int n_err = 0;
    int ext_cnt = 0;
    int so_cnt = 0;

    always #10 int_clk = ~int_clk;
    always #7  ext_clk = osc_run ? ~ext_clk : 1'b0;
    always @(posedge ext_clk) ext_cnt++;
    always @(posedge sys_clk_out) so_cnt++;

    mclk_switch_ctrl #(.BASE_EXP(BASE)) dut_i (
        .int_clk     (int_clk),
        .rst_n       (rst_n),
        .ext_clk     (ext_clk),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .osc_run     (osc_run),
        .osc_xtal    (osc_xtal),
        .osc_hgain   (osc_hgain),
        .sys_clk_out (sys_clk_out)
    );

    function automatic int milestone(input int i);
        int steps [8] = '{0, 1, 2, 3, 5, 7, 9, 10};
        return 1 << (BASE + steps[i]);
    endfunction

    function automatic bit is_thermo(input logic [7:0] v);
        return (v & 8'(v + 8'd1)) == 8'd0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge int_clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge int_clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge int_clk);
        peek(a, v);
    endtask

    task automatic count_out(output int n);
        @(negedge int_clk);
        so_cnt = 0;
        repeat (200) @(negedge int_clk);
        n = so_cnt;
    endtask

    task automatic run_settle(input int code, input bit full);
        logic [7:0] st, cc, prev;
        int bad_thermo, bad_early, flag_cyc, stat_cyc;
        bad_thermo = 0; bad_early = 0; flag_cyc = -1; stat_cyc = -1; prev = 8'd0;
        wr(3'd2, 8'(code));
        wr(3'd4, 8'h01);
        ext_cnt = 0;
        wr(3'd1, 8'h00);
        check(osc_run === 1'b1, "R3 osc_run after stop clear", int'(osc_run), 1);
        for (int cyc = 0; cyc < 8000; cyc++) begin
            @(negedge int_clk);
            peek(3'd3, st);
            peek(3'd4, cc);
            if (!is_thermo(st)) bad_thermo++;
            for (int i = 0; i < 8; i++) begin
                if (st[i] && !prev[i]) begin
                    check(ext_cnt >= milestone(i) && ext_cnt <= milestone(i) + 14,
                          $sformatf("R4 flag %0d timing", i), ext_cnt, milestone(i));
                end
            end
            prev = st;
            if (!st[code] && cc[1]) bad_early++;
            if (st[code] && flag_cyc < 0) flag_cyc = cyc;
            if (cc[1] && stat_cyc < 0) stat_cyc = cyc;
            if ((full ? (st == 8'hFF) : st[code]) && cc[1]) break;
        end
        check(bad_thermo == 0, "R4 thermometer order", bad_thermo, 0);
        check(bad_early == 0, "R6 status before flag", bad_early, 0);
        check(flag_cyc >= 0 && stat_cyc >= flag_cyc && stat_cyc - flag_cyc <= 16,
              "R6 switch latency", stat_cyc - flag_cyc, 16);
    endtask

    task automatic deselect();
        logic [7:0] cc;
        int took;
        took = -1;
        wr(3'd4, 8'h00);
        for (int i = 0; i < 16; i++) begin
            rd(3'd4, cc);
            if (!cc[1]) begin took = i; break; end
        end
        check(took >= 0, "R10 status back to internal", took, 16);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge int_clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [7:0] v, st;
        int n, code;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge int_clk);
        rst_n = 1'b1;
        @(negedge int_clk);

        // R1 reset state
        rd(3'd0, v); check(v == 8'h00, "R1 mode reset", v, 0);
        rd(3'd1, v); check(v == 8'h01, "R1 stop reset", v, 1);
        rd(3'd2, v); check(v == 8'h07, "R1 settle reset", v, 7);
        rd(3'd3, v); check(v == 8'h00, "R1 flags reset", v, 0);
        rd(3'd4, v); check(v == 8'h00, "R1 clkctl reset", v, 0);
        check(osc_run == 1'b0, "R1 osc_run reset", int'(osc_run), 0);
        count_out(n);
        check(n >= 195 && n <= 205, "R1 sys clock on internal", n, 200);

        // R2 / R9 random register traffic with the oscillator stopped
        for (int k = 0; k < 40; k++) begin
            logic [2:0] a;
            logic [7:0] d, exp_v;
            int pick;
            pick = $urandom_range(5, 0);
            case (pick)
                0: a = 3'd0;
                1: a = 3'd2;
                2: a = 3'd3;
                3: a = 3'd5;
                4: a = 3'd6;
                default: a = 3'd7;
            endcase
            d = 8'($urandom);
            wr(a, d);
            rd(a, v);
            case (a)
                3'd0: exp_v = d & 8'h03;
                3'd2: exp_v = d & 8'h07;
                default: exp_v = 8'h00;
            endcase
            check(v == exp_v, $sformatf("R9 readback addr %0d", a), v, exp_v);
            if (a == 3'd0) begin
                check(osc_xtal == d[0] && osc_hgain == d[1], "R2 mode pins",
                      {osc_hgain, osc_xtal}, d[1:0]);
            end
        end
        wr(3'd1, 8'hFF);
        rd(3'd1, v); check(v == 8'h01, "R9 stop reserved bits", v, 1);
        wr(3'd0, 8'h03);
        check(osc_xtal && osc_hgain, "R2 crystal high gain", {osc_hgain, osc_xtal}, 3);

        // R3 R4 R6 full settling with an early select
        run_settle(6, 1'b1);

        count_out(n);
        check(n >= 275 && n <= 295, "R7 sys clock on external", n, 286);

        // R8 stop ignored while external is active
        wr(3'd1, 8'h01);
        rd(3'd1, v); check(v == 8'h00, "R8 stop bit held", v, 0);
        check(osc_run == 1'b1, "R8 osc_run held", int'(osc_run), 1);

        // R9 flags not writable
        wr(3'd3, 8'h00);
        rd(3'd3, v); check(v == 8'hFF, "R9 flags write ignored", v, 255);

        // R10 back to internal
        deselect();
        count_out(n);
        check(n >= 195 && n <= 205, "R10 sys clock on internal", n, 200);

        // R5 stop clears progress
        wr(3'd1, 8'h01);
        check(osc_run == 1'b0, "R5 osc_run off", int'(osc_run), 0);
        repeat (3) @(negedge int_clk);
        peek(3'd3, st);
        check(st == 8'h00, "R5 flags cleared", st, 0);

        // second round with a random low code
        code = $urandom_range(4, 0);
        run_settle(code, 1'b0);
        rd(3'd3, v);
        check(is_thermo(v) && v[code], "R6 selected flag set at switch", v, code);
        deselect();
        wr(3'd1, 8'h01);
        rd(3'd1, v); check(v == 8'h01, "R5 stop accepted after deselect", v, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule